// File: doc/BRIEF.md
# Scan-chain test controller

This block joins a small sequential circuit and the controller that tests it. Every state flop of the circuit has a shift path. When shifting is on, each flop takes the value of the stage before it. Stage 0 takes a serial input bit, and the last stage drives a serial output. When shifting is off, each flop loads its functional next-state value. This lets the controller treat the circuit as plain combinational logic: it sets the state directly, applies one functional clock, and reads the resulting state back out.

A run starts with a pulse on `start`, with `patCount` giving the number of patterns. The controller reports which pattern it needs on `patIdx`. The environment answers with three vectors for that pattern: the state to load, the primary inputs to apply during capture, and the expected captured state. For each pattern the controller shifts the state in, holds shifting off for one capture cycle, and then shifts the captured state out. That unload overlaps with the load of the next pattern. One final unload-only pass follows the last pattern.

Each bit that is shifted out is compared with the expected vector that was latched at capture. Mismatching bits are counted across the whole run. When the run ends, `done` rises, and `fail` shows whether any bit mismatched.

Top module: `scan_test_top`

## Requirements
- R1: After reset, `scanEn`, `busy`, `done`, `fail` and `mismatchCount` are all 0.
- R2: In every shift cycle the chain moves one place toward `scanOut`, and `scanIn` enters stage 0. While a pattern is being loaded, shift step s (counting from 0) drives `scanIn` with `patVec[L-1-s]`, so the most significant bit goes first. After L steps, stage j holds `patVec[j]`.
- R3: Each pattern gets exactly one capture cycle, with `scanEn` low and `busy` high. In that cycle stage i loads `q[(i+L-1)%L] ^ (q[(i+2)%L] & piVec[i%PI_W])`, where q is the state held in the chain.
- R4: The unload of pattern k's response shares its shift cycles with the load of pattern k+1. For N patterns, a run keeps `busy` high for N·L + L + N cycles, after which `done` rises.
- R5: Shift step s of an unload compares `scanOut` with bit L-1-s of the `expVec` latched in that pattern's capture cycle. `mismatchCount` ends equal to the number of differing bits across all patterns.
- R6: `fail` is high exactly when `done` is high and `mismatchCount` is nonzero. `done`, `fail` and `mismatchCount` hold until the next accepted start.
- R7: During the final unload-only pass, `scanIn` is 0 and `patIdx` equals `patCount`.
- R8: With `FAULT_EN` set, next-state net `FAULT_BIT` is held at `FAULT_VAL`. Against fault-free expectations, the count then equals the number of patterns whose fault-free value of that bit differs from `FAULT_VAL`, and `fail` rises.
- R9: A run with a single pattern consists of one load (L cycles), one capture cycle and one unload (L cycles), 2L+1 cycles in all.
- R10: A start while `busy` is high, or a start with `patCount` equal to 0, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| start | input | 1 | Begin a run |
| patCount | input | PAT_W | Number of patterns in the run |
| patVec | input | CHAIN_LEN | State to load for pattern `patIdx` |
| expVec | input | CHAIN_LEN | Expected captured state for pattern `patIdx` |
| piVec | input | PI_W | Primary inputs applied in the capture cycle |
| patIdx | output | PAT_W | Index of the pattern currently required |
| scanEn | output | 1 | High while the chain shifts |
| scanIn | output | 1 | Serial bit fed into stage 0 |
| scanOut | output | 1 | Serial bit leaving the last stage |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| fail | output | 1 | Finished run saw at least one mismatch |
| mismatchCount | output | CNT_W | Mismatching bits counted in the run |

## Verification
The bench builds two copies with an 8-stage chain, 4 primary inputs and room for 16 patterns. The first copy is fault-free. The second has next-state bit 3 stuck at 0, so every pattern whose good value of that bit is 1 becomes a single-bit miss. An 8-stage chain keeps each run to a few dozen cycles, so the tests can cover a full six-pattern set, a single-pattern run, a run with one deliberately corrupted expected bit and a run with a stray start. Together these exercise the overlapped load and unload, the capture count and the exact mismatch totals.

// File: rtl/scan_test_pkg.sv
package scan_test_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_CAPT,
    ST_DONE
  } ctlState_t;

  // strobes from the sequencer to the compare/feed datapath
  typedef struct packed {
    logic feedPat;   // drive pattern bits into the chain
    logic cmpEn;     // compare the bit leaving the chain
    logic captExp;   // latch the expected response
    logic clrCount;  // clear the mismatch counter
  } ctlStrobe_t;

endpackage

// File: rtl/scan_cut.sv
module scan_cut #(
  parameter int CHAIN_LEN = 8,
  parameter int PI_W      = 4,
  parameter bit FAULT_EN  = 1'b0,
  parameter int FAULT_BIT = 3,
  parameter bit FAULT_VAL = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 scanEn,
  input  logic                 scanIn,
  input  logic [PI_W-1:0]      piVec,
  output logic                 scanOut
);

  logic [CHAIN_LEN-1:0] chainQ;
  logic [CHAIN_LEN-1:0] nxtRaw;
  logic [CHAIN_LEN-1:0] nxtNet;
  logic [CHAIN_LEN-1:0] stageD;

  for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_stage
    localparam int PREV = (i + CHAIN_LEN - 1) % CHAIN_LEN;
    localparam int TAP  = (i + 2) % CHAIN_LEN;
    localparam int PIB  = i % PI_W;

    assign nxtRaw[i] = chainQ[PREV] ^ (chainQ[TAP] & piVec[PIB]);

    if (FAULT_EN && (i == FAULT_BIT)) begin : g_stuck
      assign nxtNet[i] = FAULT_VAL;
    end else begin : g_clean
      assign nxtNet[i] = nxtRaw[i];
    end

    if (i == 0) begin : g_head
      assign stageD[i] = scanEn ? scanIn : nxtNet[i];
    end else begin : g_body
      assign stageD[i] = scanEn ? chainQ[i-1] : nxtNet[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chainQ <= '0;
    else       chainQ <= stageD;
  end

  assign scanOut = chainQ[CHAIN_LEN-1];

endmodule

// File: rtl/scan_ctl.sv
module scan_ctl
  import scan_test_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  parameter int MAX_PAT   = 16,
  localparam int IDX_W    = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1,
  localparam int PAT_W    = $clog2(MAX_PAT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [PAT_W-1:0] patCount,
  output ctlStrobe_t       strobe,
  output logic             scanEn,
  output logic [IDX_W-1:0] bitIdx,
  output logic [PAT_W-1:0] patIdx,
  output logic             busy,
  output logic             done
);

  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(CHAIN_LEN - 1);

  ctlState_t        state;
  logic             loadOn;
  logic             cmpOn;
  logic [PAT_W-1:0] patNext;
  logic             accept;

  assign patNext = patIdx + 1'b1;
  assign accept  = ((state == ST_IDLE) || (state == ST_DONE)) && start && (patCount != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitIdx <= '0;
      patIdx <= '0;
      loadOn <= 1'b0;
      cmpOn  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (accept) begin
            state  <= ST_SHIFT;
            bitIdx <= LAST_BIT;
            patIdx <= '0;
            loadOn <= 1'b1;
            cmpOn  <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (bitIdx == '0) state <= loadOn ? ST_CAPT : ST_DONE;
          else              bitIdx <= bitIdx - 1'b1;
        end
        ST_CAPT: begin
          state  <= ST_SHIFT;
          bitIdx <= LAST_BIT;
          patIdx <= patNext;
          loadOn <= (patNext != patCount);
          cmpOn  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.feedPat  = (state == ST_SHIFT) && loadOn;
    strobe.cmpEn    = (state == ST_SHIFT) && cmpOn;
    strobe.captExp  = (state == ST_CAPT);
    strobe.clrCount = accept;
  end

  assign scanEn = (state == ST_SHIFT);
  assign busy   = (state == ST_SHIFT) || (state == ST_CAPT);
  assign done   = (state == ST_DONE);

endmodule

// File: rtl/scan_dp.sv
module scan_dp
  import scan_test_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  parameter int MAX_PAT   = 16,
  localparam int IDX_W    = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1,
  localparam int CNT_W    = $clog2(CHAIN_LEN * MAX_PAT + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           strobe,
  input  logic [IDX_W-1:0]     bitIdx,
  input  logic [CHAIN_LEN-1:0] patVec,
  input  logic [CHAIN_LEN-1:0] expVec,
  input  logic                 scanOut,
  output logic                 scanIn,
  output logic [CNT_W-1:0]     mismatchCount
);

  logic [CHAIN_LEN-1:0] expReg;
  logic                 miss;

  assign scanIn = strobe.feedPat ? patVec[bitIdx] : 1'b0;
  assign miss   = strobe.cmpEn && (scanOut != expReg[bitIdx]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expReg        <= '0;
      mismatchCount <= '0;
    end else begin
      if (strobe.captExp) expReg <= expVec;
      if (strobe.clrCount)
        mismatchCount <= '0;
      else if (miss && (mismatchCount != {CNT_W{1'b1}}))
        mismatchCount <= mismatchCount + 1'b1;
    end
  end

endmodule

// File: rtl/scan_test_top.sv
module scan_test_top
  import scan_test_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  parameter int PI_W      = 4,
  parameter int MAX_PAT   = 16,
  parameter bit FAULT_EN  = 1'b0,
  parameter int FAULT_BIT = 3,
  parameter bit FAULT_VAL = 1'b0,
  localparam int IDX_W    = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1,
  localparam int PAT_W    = $clog2(MAX_PAT + 1),
  localparam int CNT_W    = $clog2(CHAIN_LEN * MAX_PAT + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [PAT_W-1:0]     patCount,
  input  logic [CHAIN_LEN-1:0] patVec,
  input  logic [CHAIN_LEN-1:0] expVec,
  input  logic [PI_W-1:0]      piVec,
  output logic [PAT_W-1:0]     patIdx,
  output logic                 scanEn,
  output logic                 scanIn,
  output logic                 scanOut,
  output logic                 busy,
  output logic                 done,
  output logic                 fail,
  output logic [CNT_W-1:0]     mismatchCount
);

  ctlStrobe_t       strobe;
  logic [IDX_W-1:0] bitIdx;

  scan_ctl #(.CHAIN_LEN(CHAIN_LEN), .MAX_PAT(MAX_PAT)) u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .patCount(patCount),
    .strobe(strobe), .scanEn(scanEn), .bitIdx(bitIdx), .patIdx(patIdx),
    .busy(busy), .done(done)
  );

  scan_dp #(.CHAIN_LEN(CHAIN_LEN), .MAX_PAT(MAX_PAT)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bitIdx(bitIdx),
    .patVec(patVec), .expVec(expVec), .scanOut(scanOut),
    .scanIn(scanIn), .mismatchCount(mismatchCount)
  );

  scan_cut #(
    .CHAIN_LEN(CHAIN_LEN), .PI_W(PI_W), .FAULT_EN(FAULT_EN),
    .FAULT_BIT(FAULT_BIT), .FAULT_VAL(FAULT_VAL)
  ) u_cut (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .scanIn(scanIn),
    .piVec(piVec), .scanOut(scanOut)
  );

  assign fail = done && (mismatchCount != '0);

endmodule

// File: rtl/scan_test_chk.sv
module scan_test_chk #(
  parameter int CHAIN_LEN = 8,
  parameter int MAX_PAT   = 16,
  localparam int PAT_W    = $clog2(MAX_PAT + 1),
  localparam int CNT_W    = $clog2(CHAIN_LEN * MAX_PAT + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [PAT_W-1:0] patCount,
  input logic [PAT_W-1:0] patIdx,
  input logic             scanEn,
  input logic             scanIn,
  input logic             busy,
  input logic             done,
  input logic             fail,
  input logic [CNT_W-1:0] mismatchCount
);

  // R3: a capture cycle is always followed by shifting
  p_capture_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !scanEn) |=> (busy && scanEn));

  // R3: captures only happen for patterns within the count
  p_capture_index_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !scanEn) |-> (patIdx < patCount));

  // R5: the count never falls during a run
  p_count_monotonic_r5: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (mismatchCount >= $past(mismatchCount)));

  // R6: results hold while no new start arrives
  p_done_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done && $stable(mismatchCount) && $stable(fail)));

  // R7: the final unload feeds zeros
  p_unload_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && scanEn && (patIdx == patCount)) |-> !scanIn);

  // R10: an accepted start launches a shifting run with a cleared count
  p_launch_r10: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && (patCount != '0)) |=> (busy && scanEn && (mismatchCount == '0) && (patIdx == '0)));

endmodule

bind scan_test_top scan_test_chk #(.CHAIN_LEN(CHAIN_LEN), .MAX_PAT(MAX_PAT)) chk (.*);

// File: tb/scan_test_top_test.sv
`timescale 1ns/1ps
module scan_test_top_test;

  localparam int L    = 8;
  localparam int PIW  = 4;
  localparam int MAXP = 16;
  localparam int PW   = $clog2(MAXP + 1);
  localparam int CW   = $clog2(L * MAXP + 1);
  localparam int NPAT = 6;

  // stimulus: {pattern[7:0], primary inputs[3:0]}
  localparam logic [11:0] STIM [NPAT] = '{
    {8'hFF, 4'h0}, {8'h00, 4'hF}, {8'hA5, 4'h3},
    {8'h3C, 4'hA}, {8'h81, 4'h6}, {8'h5A, 4'hC}
  };
  // runs: {pattern count, corrupted pattern index (99 = none), stray start}
  localparam int RUNS [4][3] = '{ '{6, 99, 0}, '{1, 99, 0}, '{4, 2, 0}, '{3, 99, 1} };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [PW-1:0] patCount = '0;
  int corruptIdx = 99;

  always #2.5 clk = ~clk;

  logic [PW-1:0] idxG, idxF;
  logic [L-1:0]  patG, expG, patF, expF;
  logic [PIW-1:0] piG, piF;
  logic scanEnG, scanInG, scanOutG, busyG, doneG, failG;
  logic scanEnF, scanInF, scanOutF, busyF, doneF, failF;
  logic [CW-1:0] cntG, cntF;

  function automatic logic [L-1:0] model(input logic [L-1:0] q, input logic [PIW-1:0] p);
    logic [L-1:0] n;
    for (int i = 0; i < L; i++) n[i] = q[(i+L-1)%L] ^ (q[(i+2)%L] & p[i%PIW]);
    return n;
  endfunction

  function automatic logic [L-1:0] tPat(input int k);
    return (k < NPAT) ? STIM[k][11:4] : '0;
  endfunction

  function automatic logic [PIW-1:0] tPi(input int k);
    return (k < NPAT) ? STIM[k][3:0] : '0;
  endfunction

  assign patG = tPat(int'(idxG));
  assign piG  = tPi(int'(idxG));
  assign expG = model(patG, piG) ^ ((int'(idxG) == corruptIdx) ? 8'h10 : 8'h00);
  assign patF = tPat(int'(idxF));
  assign piF  = tPi(int'(idxF));
  assign expF = model(patF, piF);

  scan_test_top #(.CHAIN_LEN(L), .PI_W(PIW), .MAX_PAT(MAXP)) uut (
    .clk(clk), .rstN(rstN), .start(start), .patCount(patCount),
    .patVec(patG), .expVec(expG), .piVec(piG), .patIdx(idxG),
    .scanEn(scanEnG), .scanIn(scanInG), .scanOut(scanOutG),
    .busy(busyG), .done(doneG), .fail(failG), .mismatchCount(cntG)
  );

  scan_test_top #(.CHAIN_LEN(L), .PI_W(PIW), .MAX_PAT(MAXP),
                  .FAULT_EN(1'b1), .FAULT_BIT(3), .FAULT_VAL(1'b0)) uutFault (
    .clk(clk), .rstN(rstN), .start(start), .patCount(patCount),
    .patVec(patF), .expVec(expF), .piVec(piF), .patIdx(idxF),
    .scanEn(scanEnF), .scanIn(scanInF), .scanOut(scanOutF),
    .busy(busyF), .done(doneF), .fail(failF), .mismatchCount(cntF)
  );

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic runOne(input int n, input int corrupt, input bit stray);
    int cycles = 0, shifts = 0, capts = 0, streamBad = 0, unloadBad = 0, guard = 0;
    int expG_mis, expF_mis;
    logic [L-1:0] p0;
    corruptIdx = corrupt;
    patCount = PW'(n);
    p0 = tPat(0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!doneG && guard < 5000) begin
      guard++;
      if (busyG) begin
        cycles++;
        if (scanEnG) begin
          if (shifts < L && scanInG !== p0[L-1-shifts]) streamBad++;
          if (shifts >= n*L && scanInG !== 1'b0) unloadBad++;
          shifts++;
        end else capts++;
      end
      start = stray && (cycles == 5);
      @(negedge clk);
    end
    start = 1'b0;
    check(guard < 5000, "R4", "run finished before timeout", guard, 0);
    expG_mis = (corrupt < n) ? 1 : 0;
    expF_mis = 0;
    for (int k = 0; k < n; k++) begin
      logic [L-1:0] g;
      g = model(tPat(k), tPi(k));
      if (g[3] != 1'b0) expF_mis++;
    end
    check(cycles == n*L + L + n, (n == 1) ? "R9" : (stray ? "R10" : "R4"), "busy cycles", cycles, n*L + L + n);
    check(capts == n, "R3", "capture cycles", capts, n);
    check(shifts == n*L + L, "R2", "shift cycles", shifts, n*L + L);
    check(streamBad == 0, "R2", "first pattern serial order", streamBad, 0);
    check(unloadBad == 0, "R7", "zeros fed in final unload", unloadBad, 0);
    check(int'(cntG) == expG_mis, "R5", "mismatch count", int'(cntG), expG_mis);
    check(failG == (expG_mis != 0), "R6", "fail flag", int'(failG), int'(expG_mis != 0));
    if (corrupt >= NPAT) begin
      check(int'(cntF) == expF_mis, "R8", "faulty mismatch count", int'(cntF), expF_mis);
      check(failF == (expF_mis != 0) && doneF, "R8", "faulty fail flag", int'(failF), int'(expF_mis != 0));
    end
    repeat (3) @(negedge clk);
    check(doneG && int'(cntG) == expG_mis, "R6", "result held after run", int'(cntG), expG_mis);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=1 expected=0");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!scanEnG && !busyG && !doneG && !failG && cntG == '0, "R1", "reset outputs",
          int'({scanEnG, busyG, doneG, failG}), 0);
    rstN = 1'b1;
    @(negedge clk);
    // zero-count start is ignored
    patCount = '0;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(!busyG && !doneG, "R10", "zero-count start ignored", int'(busyG), 0);
    @(negedge clk);
    check(!busyG && !doneG && !scanEnG, "R10", "still idle after zero-count start", int'(busyG), 0);
    for (int r = 0; r < 4; r++) runOne(RUNS[r][0], RUNS[r][1], RUNS[r][2] != 0);
    finishRun();
  end

endmodule